// File: doc/BRIEF.md
# Transmit Dominant Time-out Guard

This block sits in the transmit path between the serial transmit data input of a bus node and the enable of its line driver. The transmit input is active low: a low level asks the driver to put a dominant level on the bus. The guard passes that request through unchanged while the node behaves, but counts how long the input has been held low without a break. A transmit input stuck low, caused by a software or hardware fault, would otherwise block the whole network. Once the count reaches a programmable limit, the guard forces the driver to recessive.

After such a time-out the driver stays released until the transmit input has been high for a minimum number of consecutive clock cycles. A single short high pulse is not enough. A separate overtemperature flag also forces the driver off. Driving resumes only once the flag has cleared and the transmit input is high. Two sticky flags report which fault is pending, and both clear together at the moment normal driving resumes. Both time limits are given in clock cycles.

Top module: `txdom_guard`

## Requirements
- R1: While reset is held, and on the first cycle after it, the driver is not enabled for a high transmit input and both fault flags read 0. Reset also abandons any pending fault.
- R2: With no fault pending, `drv_dom` equals the inverse of `tx_in` in the same cycle (low = dominant). It is never 1 while `tx_in` is high.
- R3: If `tx_in` is sampled low on TO_CYCLES consecutive rising edges, the guard is in time-out from that edge on. `drv_dom` is then 0 and `timeout_flt` is 1.
- R4: A single high sample before the limit is reached restarts the low count, so a further TO_CYCLES low samples are needed for a time-out.
- R5: In time-out, the guard returns to normal on the REC_CYCLES-th consecutive high sample of `tx_in`. Until then `drv_dom` stays 0, even with `tx_in` low. On return, `timeout_flt` clears.
- R6: A low sample during time-out recovery restarts the high count from zero.
- R7: `overtemp` sampled high on an edge puts the guard in thermal hold from that edge, from any state. `drv_dom` is 0 and `thermal_flt` is 1 from then on. On the same edge this takes priority over a time-out expiry, which then does not set `timeout_flt`.
- R8: Thermal hold ends only on an edge where `overtemp` is low and `tx_in` is high together. A cleared flag with a low input keeps the hold.
- R9: If a time-out is pending when thermal hold ends, the guard goes into time-out recovery with a fresh high count. Both flags stay set until normal driving resumes, and both clear together then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_in | input | 1 | Transmit data from the controller, low = dominant |
| overtemp | input | 1 | Overtemperature indication, high = too hot |
| drv_dom | output | 1 | Gated driver request, high = drive dominant |
| timeout_flt | output | 1 | Sticky flag: a dominant time-out is pending |
| thermal_flt | output | 1 | Sticky flag: a thermal shutdown is pending |

## Verification
The hardest situations to reach are the ones where the two faults overlap. One case is an overtemperature arriving while a time-out recovery is under way. The other is an overtemperature on the very edge on which the low count would expire. To reach them, the stimulus first counts exactly TO_CYCLES-1 or TO_CYCLES low samples. It then raises the overtemperature flag on the next vector, with small parameter values so that each edge can be placed by hand. Then it releases heat while the time-out is still pending. This shows that a fresh qualified high period is still required, and that both flags clear together on the same edge.

// File: rtl/txg_pkg.sv
// Package: shared state encoding for the transmit dominant time-out guard.
// Assumes: used by all guard modules; no other dependencies.
package txg_pkg;

    // Guard operating states.
    typedef enum logic [1:0] {
        GS_RUN  = 2'd0,   // transmit input passed to the driver
        GS_TOUT = 2'd1,   // dominant time-out, awaiting qualified high period
        GS_HOT  = 2'd2    // thermal hold, awaiting cool and high input
    } guard_st_e;

endpackage

// File: rtl/txg_low_timer.sv
// Module: counts consecutive low samples of the transmit input.
// Emits `expire` combinationally on the edge where the TO_CYCLES-th
// consecutive low sample would be taken.
// Assumes: `clr` is held whenever the guard is not in normal running.
module txg_low_timer #(
    parameter int unsigned TO_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tx_in,
    output logic expire
);
    localparam int unsigned CW = $clog2(TO_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(TO_CYCLES - 1);

    logic [CW-1:0] lo_cnt;

    // Expiry fires when this low sample completes the limit.
    assign expire = !clr && !tx_in && (lo_cnt == LAST);

    // Count consecutive low samples, restart on any high sample or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tx_in) begin
            lo_cnt <= '0;
        end else if (lo_cnt != LAST) begin
            lo_cnt <= lo_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/txg_high_qual.sv
// Module: qualifies a high period on the transmit input after a time-out.
// `done` fires on the edge where the REC_CYCLES-th consecutive high
// sample is taken; any low sample restarts the count.
// Assumes: `clr` is held whenever the guard is not in time-out recovery.
module txg_high_qual #(
    parameter int unsigned REC_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tx_in,
    output logic done
);
    localparam int unsigned CW = $clog2(REC_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(REC_CYCLES - 1);

    logic [CW-1:0] hi_cnt;

    // Recovery completes when this high sample fills the window.
    assign done = !clr && tx_in && (hi_cnt == LAST);

    // Count consecutive high samples, restart on a low sample or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !tx_in) begin
            hi_cnt <= '0;
        end else if (hi_cnt != LAST) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/txg_fault_fsm.sv
// Module: guard state machine and sticky fault flags.
// Overtemperature has priority over every other event. Thermal release
// needs a cool flag and a high input. A pending time-out sends the
// guard through qualified recovery before it runs again.
// Assumes: `expire` and `done` come from the two timers, gated by state.
module txg_fault_fsm
    import txg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tx_in,
    input  logic      overtemp,
    input  logic      expire,
    input  logic      done,
    output guard_st_e state,
    output logic      to_flag,
    output logic      th_flag
);
    guard_st_e nxt;

    // Next-state selection; heat wins over every other event.
    always_comb begin
        nxt = state;
        if (overtemp) begin
            nxt = GS_HOT;
        end else begin
            unique case (state)
                GS_RUN:  if (expire) nxt = GS_TOUT;
                GS_TOUT: if (done)   nxt = GS_RUN;
                GS_HOT:  if (tx_in)  nxt = to_flag ? GS_TOUT : GS_RUN;
                default: nxt = GS_RUN;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= GS_RUN;
        else        state <= nxt;
    end

    // Sticky flags: set on fault entry, cleared together on return to run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_flag <= 1'b0;
            th_flag <= 1'b0;
        end else if (nxt == GS_RUN) begin
            to_flag <= 1'b0;
            th_flag <= 1'b0;
        end else begin
            if (state == GS_RUN && nxt == GS_TOUT) to_flag <= 1'b1;
            if (overtemp)                          th_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/txdom_guard.sv
// Module: transmit dominant time-out guard (top).
// Passes the active-low transmit request to the driver. The driver is
// released after TO_CYCLES consecutive low samples, or while the chip is
// too hot. Sticky flags report the pending fault.
// Assumes: tx_in and overtemp are synchronous to clk.
module txdom_guard
    import txg_pkg::*;
#(
    parameter int unsigned TO_CYCLES  = 100000,
    parameter int unsigned REC_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_in,
    input  logic overtemp,
    output logic drv_dom,
    output logic timeout_flt,
    output logic thermal_flt
);
    guard_st_e state;
    logic      expire;
    logic      done;
    logic      to_flag;
    logic      th_flag;

    // Low-period timer, active only while running.
    txg_low_timer #(.TO_CYCLES(TO_CYCLES)) u_low (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state != GS_RUN),
        .tx_in  (tx_in),
        .expire (expire)
    );

    // High-period qualifier, active only in time-out recovery.
    txg_high_qual #(.REC_CYCLES(REC_CYCLES)) u_high (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state != GS_TOUT),
        .tx_in (tx_in),
        .done  (done)
    );

    // State machine and fault flags.
    txg_fault_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_in    (tx_in),
        .overtemp (overtemp),
        .expire   (expire),
        .done     (done),
        .state    (state),
        .to_flag  (to_flag),
        .th_flag  (th_flag)
    );

    // Driver request gated by state; flags straight from the registers.
    assign drv_dom     = (state == GS_RUN) && !tx_in;
    assign timeout_flt = to_flag;
    assign thermal_flt = th_flag;
endmodule

// File: rtl/txg_checker.sv
// Module: property checker for the transmit dominant time-out guard,
// attached to every instance of the top through the bind below.
// Assumes: sees only the top-level ports.
module txg_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_in,
    input logic overtemp,
    input logic drv_dom,
    input logic timeout_flt,
    input logic thermal_flt
);
    // The driver is only ever dominant for a low request.
    assert_drv_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        drv_dom |-> !tx_in);

    // A new time-out flag follows a low sample.
    assert_timeout_after_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flt) |-> $past(!tx_in));

    // Either pending fault keeps the driver released.
    assert_fault_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flt || thermal_flt) |-> !drv_dom);

    // A hot sample sets the thermal flag on the next cycle.
    assert_hot_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overtemp |=> thermal_flt);

    // Thermal release needs a cool flag together with a high input.
    assert_thermal_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(thermal_flt) |-> ($past(tx_in) && !$past(overtemp)));

    // Time-out recovery ends on a high sample, never while hot.
    assert_timeout_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(timeout_flt) |-> ($past(tx_in) && !$past(overtemp)));

    // Flags clear together when driving resumes.
    assert_flags_clear_together_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(timeout_flt) && $past(thermal_flt)) |-> !thermal_flt);
endmodule

bind txdom_guard txg_checker u_txg_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_in       (tx_in),
    .overtemp    (overtemp),
    .drv_dom     (drv_dom),
    .timeout_flt (timeout_flt),
    .thermal_flt (thermal_flt)
);

// File: tb/test_txdom_guard.sv
// Bench for the transmit dominant time-out guard. A vector table walked
// one clock per entry, then directed reset tests.
module test_txdom_guard;
    localparam int unsigned TO  = 8;
    localparam int unsigned REC = 4;
    localparam int NV = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_in = 1'b1;
    logic overtemp = 1'b0;
    logic drv_dom, timeout_flt, thermal_flt;
    int   errors = 0;
    int   checks = 0;

    always #4 clk = ~clk;

    txdom_guard #(.TO_CYCLES(TO), .REC_CYCLES(REC)) i_txdom_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_in       (tx_in),
        .overtemp    (overtemp),
        .drv_dom     (drv_dom),
        .timeout_flt (timeout_flt),
        .thermal_flt (thermal_flt)
    );

    // Entry: {tx_in, overtemp}_{drv_dom, timeout_flt, thermal_flt}_{requirement}
    localparam logic [8:0] VEC [NV] = '{
        9'b10_000_0010, 9'b00_100_0010, 9'b00_100_0010,                  // R2
        9'b10_000_0100,                                                  // R4
        9'b00_100_0100, 9'b00_100_0100, 9'b00_100_0100, 9'b00_100_0100,
        9'b00_100_0100, 9'b00_100_0100, 9'b00_100_0100,                  // R4: seven lows
        9'b10_000_0100,                                                  // R4: high clears
        9'b00_100_0011, 9'b00_100_0011, 9'b00_100_0011, 9'b00_100_0011,
        9'b00_100_0011, 9'b00_100_0011, 9'b00_100_0011,                  // R3
        9'b00_010_0011, 9'b00_010_0011,                                  // R3: expiry
        9'b10_010_0101, 9'b10_010_0101, 9'b10_010_0101,                  // R5
        9'b00_010_0110,                                                  // R6: break
        9'b10_010_0110, 9'b10_010_0110, 9'b10_010_0110,                  // R6
        9'b10_000_0101,                                                  // R5: release
        9'b00_100_0010,                                                  // R2
        9'b01_001_0111,                                                  // R7
        9'b00_001_1000, 9'b11_001_1000, 9'b10_000_1000,                  // R8
        9'b00_100_0010, 9'b10_000_0010,
        9'b00_100_0011, 9'b00_100_0011, 9'b00_100_0011, 9'b00_100_0011,
        9'b00_100_0011, 9'b00_100_0011, 9'b00_100_0011,
        9'b00_010_0011,                                                  // R3
        9'b11_011_1001, 9'b10_011_1001,                                  // R9
        9'b10_011_1001, 9'b10_011_1001, 9'b10_011_1001,
        9'b10_000_1001,                                                  // R9: both clear
        9'b10_000_0111,
        9'b00_100_0111, 9'b00_100_0111, 9'b00_100_0111, 9'b00_100_0111,
        9'b00_100_0111, 9'b00_100_0111, 9'b00_100_0111,
        9'b01_001_0111,                                                  // R7: same-edge priority
        9'b10_000_1000                                                   // R8
    };

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: drv/to/th actual=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic step(input logic t, input logic o);
        tx_in = t;
        overtemp = o;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        tx_in = 1'b1;
        overtemp = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", {drv_dom, timeout_flt, thermal_flt}, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][8], VEC[i][7]);
            check($sformatf("R%0d vec%0d", VEC[i][3:0], i), {drv_dom, timeout_flt, thermal_flt}, VEC[i][6:4]);
        end
        // R3: drive into time-out, then R1: reset abandons it
        for (int i = 0; i < int'(TO); i++) step(1'b0, 1'b0);
        check("R3", {drv_dom, timeout_flt, thermal_flt}, 3'b010);
        step(1'b1, 1'b1);
        check("R7", {drv_dom, timeout_flt, thermal_flt}, 3'b011);
        rst_n = 1'b0;
        step(1'b1, 1'b0);
        check("R1", {drv_dom, timeout_flt, thermal_flt}, 3'b000);
        rst_n = 1'b1;
        step(1'b0, 1'b0);
        check("R1", {drv_dom, timeout_flt, thermal_flt}, 3'b100);
        // R5: REC-1 highs leave driver off, the REC-th releases
        step(1'b1, 1'b0);
        for (int i = 0; i < int'(TO); i++) step(1'b0, 1'b0);
        for (int i = 0; i < int'(REC) - 1; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        check("R5", {drv_dom, timeout_flt, thermal_flt}, 3'b010);
        for (int i = 0; i < int'(REC); i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        check("R5", {drv_dom, timeout_flt, thermal_flt}, 3'b100);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule